// File: doc/BRIEF.md
# Power Register Access Command Engine

This block sits on the controller side of a host mailbox. When a command arrives, the mailbox latches a command code, a sub-command id, a payload size and a 16-byte payload, and then pulses `start`. The engine applies the command to a local file of 8-bit power-management registers. Each register has a 16-bit address.

Three operations are recognised under one command code:
- a read of up to five registers, which returns their values in a read buffer;
- a write of up to five registers;
- a masked read-modify-write of one register.

Each register in an operation takes one clock cycle. The end of every accepted command is marked by a one-cycle `done` pulse, which carries an error flag and an error code. A malformed command fails at once and does not touch the register file.

Top module: `pre_engine`

## Requirements
- R1: A `start` pulse is acted on only when `cmd_code` is 0xFF and the engine is idle. Any other start gives no `done` and changes neither the register file nor `rbuf`.
- R2: Sub-command 1 (read) takes N = size/2 registers. Address k is held in payload bytes 2k (low byte) and 2k+1 (high byte). The value of that register appears in `rbuf` byte k. Every `rbuf` byte that the command does not fill reads zero after each accepted command.
- R3: Sub-command 0 (write) takes N = size/3 registers. The addresses are packed as in R2. Data byte k is in payload byte 2N+k and is written to address k.
- R4: Sub-command 2 (read-modify-write) needs size 4. Payload bytes 0–1 hold the address, byte 2 the value and byte 3 the mask. A register bit takes the value bit where the mask bit is 1 and keeps its old value where the mask bit is 0.
- R5: A size that does not fit the sub-command fails with error code 2 and leaves the register file unchanged. Such sizes are: odd for a read, not a multiple of 3 for a write, an N outside 1..5, or anything other than 4 for a read-modify-write.
- R6: A sub-command id other than 0, 1 or 2 fails with error code 1.
- R7: A command that names an address at or above the register count (32) fails with error code 3 and writes nothing.
- R8: `done` is high for exactly one cycle. For an accepted command over N registers, it rises N clock edges after the edge that samples `start`. For a failed command it is high right after that sampling edge.
- R9: After reset, `done`, `error`, `err_code` and `rbuf` are zero, and every register reads 0x00.
- R10: A command that succeeds finishes with `error` = 0 and `err_code` = 0. A failed one finishes with `error` = 1 and a nonzero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse: latched command is ready |
| cmd_code | input | 8 | Command code; 0xFF selects this engine |
| sub_id | input | 4 | Sub-command: 0 write, 1 read, 2 read-modify-write |
| size | input | 8 | Payload size in bytes |
| wbuf | input | 128 | Payload, byte 0 in bits 7:0 |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag of the last command |
| err_code | output | 8 | 0 ok, 1 bad sub-command, 2 bad size, 3 address out of range |
| rbuf | output | 128 | Read results, byte k in bits 8k+7:8k |

## Verification
The main path is driven with writes, then reads, over a range of address lists:
- ascending runs, which check the byte packing;
- scattered and descending lists, which show that each address is decoded on its own and does not follow the position in the list;
- a list that wraps from the top register to the bottom one, which exercises the highest index.

The register counts vary from one to five, so the latency check can tell a per-register pace apart from a fixed delay. A read-modify-write with a half mask shows that the untouched bits keep their old value. Each error class is followed by a read-back, which shows that a rejected command left the file as it was.

// File: rtl/pre_pkg.sv
package pre_pkg;
   typedef enum logic [3:0] {
      OP_WRITE = 4'd0,
      OP_READ  = 4'd1,
      OP_RMW   = 4'd2
   } op_e;

   localparam logic [7:0] ERR_NONE = 8'd0;
   localparam logic [7:0] ERR_SUB  = 8'd1;
   localparam logic [7:0] ERR_SIZE = 8'd2;
   localparam logic [7:0] ERR_ADDR = 8'd3;
endpackage

// File: rtl/pre_decode.sv
// Validates a latched command and derives its register count.
module pre_decode #(
   parameter int REG_COUNT = 32,
   parameter int MAX_REGS  = 5,
   parameter int ADDR_W    = 16,
   localparam int CNT_W    = $clog2(MAX_REGS + 1)
) (
   input  logic [3:0]                 sub_id,
   input  logic [7:0]                 size,
   input  logic [MAX_REGS*ADDR_W-1:0] addr_list,
   output logic                       ok,
   output logic [7:0]                 code,
   output logic [CNT_W-1:0]           count
);
   import pre_pkg::*;

   logic [7:0]          n_raw;
   logic                sub_bad;
   logic                size_bad;
   logic [MAX_REGS-1:0] addr_bad;

   always_comb begin
      sub_bad  = 1'b0;
      size_bad = 1'b0;
      n_raw    = 8'd0;
      unique case (sub_id)
         4'(OP_WRITE): begin
            n_raw    = size / 8'd3;
            size_bad = (size % 8'd3 != 8'd0) || n_raw == 8'd0 || 32'(n_raw) > MAX_REGS;
         end
         4'(OP_READ): begin
            n_raw    = size >> 1;
            size_bad = size[0] || n_raw == 8'd0 || 32'(n_raw) > MAX_REGS;
         end
         4'(OP_RMW): begin
            n_raw    = 8'd1;
            size_bad = size != 8'd4;
         end
         default: sub_bad = 1'b1;
      endcase
   end

   for (genvar j = 0; j < MAX_REGS; j++) begin : g_addr_chk
      assign addr_bad[j] = (32'(n_raw) > j) &&
                           (32'(addr_list[j*ADDR_W +: ADDR_W]) >= REG_COUNT);
   end

   always_comb begin
      if (sub_bad)        code = ERR_SUB;
      else if (size_bad)  code = ERR_SIZE;
      else if (|addr_bad) code = ERR_ADDR;
      else                code = ERR_NONE;
   end

   assign ok    = (code == ERR_NONE);
   assign count = CNT_W'(n_raw);
endmodule

// File: rtl/pre_regfile.sv
// Byte-wide register file, one write port and one combinational read port.
module pre_regfile #(
   parameter int REG_COUNT = 32,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = $clog2(REG_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [REG_COUNT];

   for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          mem[r] <= '0;
         else if (we && 32'(idx) == r)        mem[r] <= wdata;
      end
   end

   assign rdata = mem[idx];
endmodule

// File: rtl/pre_engine.sv
// Power register access command engine: top level.
module pre_engine #(
   parameter int          REG_COUNT  = 32,
   parameter int          MAX_REGS   = 5,
   parameter int          ADDR_W     = 16,
   parameter int          WBUF_BYTES = 16,
   parameter int          RBUF_BYTES = 16,
   parameter logic [7:0]  CMD_CODE   = 8'hFF,
   localparam int         IDX_W      = $clog2(REG_COUNT),
   localparam int         CNT_W      = $clog2(MAX_REGS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [7:0]              cmd_code,
   input  logic [3:0]              sub_id,
   input  logic [7:0]              size,
   input  logic [WBUF_BYTES*8-1:0] wbuf,
   output logic                    done,
   output logic                    error,
   output logic [7:0]              err_code,
   output logic [RBUF_BYTES*8-1:0] rbuf
);
   import pre_pkg::*;

   if (WBUF_BYTES < 3 * MAX_REGS) begin : g_bad_wbuf
      $error("write buffer too small for MAX_REGS");
   end
   if (RBUF_BYTES < MAX_REGS) begin : g_bad_rbuf
      $error("read buffer too small for MAX_REGS");
   end
   if (REG_COUNT != (1 << IDX_W) || IDX_W > ADDR_W) begin : g_bad_count
      $error("REG_COUNT must be a power of two within the address width");
   end

   typedef enum logic {ST_IDLE, ST_RUN} st_e;

   st_e                     st_q;
   logic [3:0]              op_q;
   logic [CNT_W-1:0]        cnt_q, idx_q;
   logic [WBUF_BYTES*8-1:0] wbuf_q;
   logic [RBUF_BYTES*8-1:0] rbuf_q;
   logic                    done_q, err_q;
   logic [7:0]              code_q;

   logic                    busy, accept, last;
   logic                    dec_ok;
   logic [7:0]              dec_code;
   logic [CNT_W-1:0]        dec_cnt;
   logic [IDX_W-1:0]        cur_idx;
   logic [7:0]              rd_byte, wr_byte, rmw_val, rmw_mask, wdata;
   logic                    we;

   assign busy   = (st_q == ST_RUN);
   assign accept = start && (cmd_code == CMD_CODE) && !busy;

   pre_decode #(
      .REG_COUNT(REG_COUNT), .MAX_REGS(MAX_REGS), .ADDR_W(ADDR_W)
   ) i_decode (
      .sub_id   (sub_id),
      .size     (size),
      .addr_list(wbuf[MAX_REGS*ADDR_W-1:0]),
      .ok       (dec_ok),
      .code     (dec_code),
      .count    (dec_cnt)
   );

   // Operand selection for the register handled this cycle.
   assign cur_idx  = wbuf_q[32'(idx_q)*ADDR_W +: IDX_W];
   assign wr_byte  = wbuf_q[(32'(cnt_q)*2 + 32'(idx_q))*8 +: 8];
   assign rmw_val  = wbuf_q[16 +: 8];
   assign rmw_mask = wbuf_q[24 +: 8];
   assign wdata    = (op_q == 4'(OP_RMW)) ? ((rd_byte & ~rmw_mask) | (rmw_val & rmw_mask))
                                          : wr_byte;
   assign we       = busy && (op_q == 4'(OP_WRITE) || op_q == 4'(OP_RMW));
   assign last     = (idx_q == cnt_q - CNT_W'(1));

   pre_regfile #(.REG_COUNT(REG_COUNT), .DATA_W(8)) i_regfile (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (we),
      .idx  (cur_idx),
      .wdata(wdata),
      .rdata(rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         op_q   <= '0;
         cnt_q  <= '0;
         idx_q  <= '0;
         wbuf_q <= '0;
         rbuf_q <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         code_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            rbuf_q <= '0;
            wbuf_q <= wbuf;
            op_q   <= sub_id;
            cnt_q  <= dec_cnt;
            idx_q  <= '0;
            if (dec_ok) begin
               st_q   <= ST_RUN;
               err_q  <= 1'b0;
               code_q <= ERR_NONE;
            end else begin
               done_q <= 1'b1;
               err_q  <= 1'b1;
               code_q <= dec_code;
            end
         end else if (busy) begin
            if (op_q == 4'(OP_READ)) rbuf_q[32'(idx_q)*8 +: 8] <= rd_byte;
            if (last) begin
               st_q   <= ST_IDLE;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + CNT_W'(1);
            end
         end
      end
   end

   assign done     = done_q;
   assign error    = err_q;
   assign err_code = code_q;
   assign rbuf     = rbuf_q;
endmodule

// File: rtl/pre_engine_chk.sv
// Protocol checker for pre_engine, attached by bind.
module pre_engine_chk #(
   parameter logic [7:0] CMD_CODE = 8'hFF
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic [7:0] cmd_code,
   input logic       busy,
   input logic       done,
   input logic       error,
   input logic [7:0] err_code
);
   // R8: done does not stay high unless a new start fails at once
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   // R10: failure always carries a nonzero code
   assert_err_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && error) |-> (err_code != 8'd0));

   // R10: success carries code zero
   assert_ok_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !error) |-> (err_code == 8'd0));

   // R1: idle with no start for this engine produces no completion
   assert_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(start && cmd_code == CMD_CODE)) |=> !done);

   // R5: a failed command never went through the busy phase
   assert_reject_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && error) |-> !$past(busy));
endmodule

bind pre_engine pre_engine_chk #(.CMD_CODE(CMD_CODE)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .cmd_code(cmd_code),
   .busy    (busy),
   .done    (done),
   .error   (error),
   .err_code(err_code)
);

// File: tb/test_pre_engine.sv
module test_pre_engine;
   localparam int CLK_PERIOD = 10;
   localparam int NREG = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [7:0]   cmd_code = 8'h00;
   logic [3:0]   sub_id = 4'd0;
   logic [7:0]   size = 8'd0;
   logic [127:0] wbuf = '0;
   logic         done, error;
   logic [7:0]   err_code;
   logic [127:0] rbuf;

   int n_checks = 0;
   int n_errs   = 0;

   pre_engine i_pre_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code),
      .sub_id(sub_id), .size(size), .wbuf(wbuf),
      .done(done), .error(error), .err_code(err_code), .rbuf(rbuf)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Vector: op, count, first address, step (mask for RMW), first data (value for RMW)
   typedef struct packed {
      logic [3:0]        op;
      logic [3:0]        n;
      logic [7:0]        addr0;
      logic signed [7:0] step;
      logic [7:0]        dat0;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{4'd0, 4'd5, 8'd0,  8'sd1,   8'h10},
      '{4'd1, 4'd5, 8'd0,  8'sd1,   8'h00},
      '{4'd0, 4'd3, 8'd20, 8'sd3,   8'hA0},
      '{4'd1, 4'd4, 8'd26, -8'sd3,  8'h00},
      '{4'd0, 4'd1, 8'd31, 8'sd0,   8'h5E},
      '{4'd1, 4'd2, 8'd31, -8'sd31, 8'h00},
      '{4'd2, 4'd1, 8'd2,  8'sh0F,  8'hA5},
      '{4'd1, 4'd3, 8'd1,  8'sd1,   8'h00}
   };

   logic [7:0]   mdl [NREG];
   logic         r_seen, r_err;
   logic [7:0]   r_code;
   logic [127:0] r_rbuf;
   int           r_lat;

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_cmd(input logic [7:0] code, input logic [3:0] sub, input logic [7:0] sz,
                         input logic [127:0] pl, input int maxw);
      @(negedge clk);
      start = 1'b1; cmd_code = code; sub_id = sub; size = sz; wbuf = pl;
      @(negedge clk);
      start = 1'b0;
      r_seen = 1'b0; r_lat = 0;
      while (!r_seen && r_lat <= maxw) begin
         if (done) begin
            r_seen = 1'b1; r_err = error; r_code = err_code; r_rbuf = rbuf;
         end else begin
            r_lat++;
            @(negedge clk);
         end
      end
      if (r_seen) begin
         @(negedge clk);
         chk(done == 1'b0, "R8 done single cycle", 128'(done), 128'd0);
      end
   endtask

   // Read list of addresses, compare with model
   task automatic read_back(input int a0, input int n, input string req);
      logic [127:0] pl = '0;
      logic [127:0] exp = '0;
      for (int k = 0; k < n; k++) begin
         pl[k*16 +: 16] = 16'(a0 + k);
         exp[k*8 +: 8]  = mdl[a0 + k];
      end
      do_cmd(8'hFF, 4'd1, 8'(2*n), pl, 20);
      chk(r_seen && !r_err && r_rbuf == exp, req, r_rbuf, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      logic [127:0] pl;
      logic [127:0] exp;
      logic [127:0] keep;
      for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;

      repeat (3) @(negedge clk);
      chk(done == 0 && error == 0 && err_code == 0, "R9 reset flags", {done, error, err_code}, 0);
      chk(rbuf == '0, "R9 reset rbuf", rbuf, 0);
      rst_n = 1'b1;
      read_back(0, 5, "R9 registers zero after reset");

      // Table walk: R2 R3 R4 R8 R10
      for (int v = 0; v < NVEC; v++) begin
         int n;
         int addr [5];
         n = int'(VECS[v].n);
         pl = '0; exp = '0;
         for (int k = 0; k < n; k++) addr[k] = int'(VECS[v].addr0) + k * int'($signed(VECS[v].step));
         if (VECS[v].op == 4'd2) begin
            pl[15:0] = 16'(addr[0]); pl[23:16] = VECS[v].dat0; pl[31:24] = VECS[v].step;
            do_cmd(8'hFF, 4'd2, 8'd4, pl, 20);
            mdl[addr[0]] = (mdl[addr[0]] & ~VECS[v].step) | (VECS[v].dat0 & VECS[v].step);
            chk(r_seen && !r_err && r_code == 0, "R4 rmw ok", {r_err, r_code}, 0);
            chk(r_lat == 1, "R8 rmw latency", r_lat, 1);
         end else begin
            for (int k = 0; k < n; k++) begin
               pl[k*16 +: 16] = 16'(addr[k]);
               if (VECS[v].op == 4'd0) pl[(2*n + k)*8 +: 8] = VECS[v].dat0 + 8'(k * 17);
               else exp[k*8 +: 8] = mdl[addr[k]];
            end
            do_cmd(8'hFF, VECS[v].op, 8'((VECS[v].op == 4'd0 ? 3 : 2) * n), pl, 20);
            chk(r_seen && !r_err && r_code == 0, "R10 success status", {r_err, r_code}, 0);
            chk(r_lat == n, "R8 latency equals count", r_lat, n);
            if (VECS[v].op == 4'd1) chk(r_rbuf == exp, "R2 read data", r_rbuf, exp);
            else begin
               chk(r_rbuf == '0, "R2 rbuf cleared on write", r_rbuf, 0);
               for (int k = 0; k < n; k++) mdl[addr[k]] = VECS[v].dat0 + 8'(k * 17);
            end
         end
      end
      read_back(0, 5, "R3 R4 final low registers");

      // R6: unknown sub-command
      do_cmd(8'hFF, 4'd3, 8'd2, 128'h0, 20);
      chk(r_seen && r_err && r_code == 8'd1, "R6 bad sub code 1", {r_err, r_code}, {1'b1, 8'd1});
      chk(r_lat == 0, "R8 reject latency", r_lat, 0);

      // R5: size errors, file untouched
      pl = '0;
      for (int k = 0; k < 6; k++) pl[k*16 +: 16] = 16'(k);
      pl[127:96] = 32'hEEEEEEEE;
      do_cmd(8'hFF, 4'd0, 8'd18, pl, 20);
      chk(r_seen && r_err && r_code == 8'd2, "R5 write six regs", {r_err, r_code}, {1'b1, 8'd2});
      do_cmd(8'hFF, 4'd1, 8'd3, pl, 20);
      chk(r_seen && r_err && r_code == 8'd2, "R5 odd read size", {r_err, r_code}, {1'b1, 8'd2});
      do_cmd(8'hFF, 4'd1, 8'd0, pl, 20);
      chk(r_seen && r_err && r_code == 8'd2, "R5 zero size", {r_err, r_code}, {1'b1, 8'd2});
      do_cmd(8'hFF, 4'd2, 8'd3, 128'h0F_FF_0000, 20);
      chk(r_seen && r_err && r_code == 8'd2, "R5 rmw size", {r_err, r_code}, {1'b1, 8'd2});
      do_cmd(8'hFF, 4'd0, 8'd4, 128'h00_EE_0001, 20);
      chk(r_seen && r_err && r_code == 8'd2, "R5 write size not multiple", {r_err, r_code}, {1'b1, 8'd2});
      read_back(0, 5, "R5 file untouched after size errors");

      // R7: out-of-range addresses
      pl = '0; pl[15:0] = 16'd3; pl[31:16] = 16'd40; pl[39:32] = 8'h77; pl[47:40] = 8'h77;
      do_cmd(8'hFF, 4'd0, 8'd6, pl, 20);
      chk(r_seen && r_err && r_code == 8'd3, "R7 write addr range", {r_err, r_code}, {1'b1, 8'd3});
      do_cmd(8'hFF, 4'd2, 8'd4, 128'hFF_FF_0100, 20);
      chk(r_seen && r_err && r_code == 8'd3, "R7 rmw addr range", {r_err, r_code}, {1'b1, 8'd3});
      read_back(0, 5, "R7 file untouched after address error");

      // R1: foreign command code ignored
      keep = rbuf;
      do_cmd(8'hFE, 4'd0, 8'd3, 128'h99_0000, 8);
      chk(!r_seen, "R1 no done on foreign code", r_seen, 0);
      chk(rbuf == keep, "R1 rbuf unchanged", rbuf, keep);
      read_back(0, 1, "R1 register unchanged");

      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule